// File: doc/BRIEF.md
# DS1 Robbed-Bit Signaling Change Detector

This block sits behind a DS1 receive framer. It watches the aligned timeslot bytes of each frame and pulls the robbed signaling bit out of the signaling frames. It builds a four-bit signaling word for every one of the 24 voice channels across a multiframe. At each multiframe boundary it compares every new word with the word held from the previous multiframe. It then stores the new words and latches a per-channel change bitmap for software to read.

A single summary flag records that some channel changed while the interrupt enable was set. The interrupt output follows that flag, gated by the enable. Software clears the flag in one of two ways, chosen by a control input: reading the status location clears it, or writing a one to its bit clears it. All results are read through a small register port with one cycle of read latency.

Top module: `ds1_sig_watch`

## Requirements
- R1: After reset, every stored signaling word, all three change bitmaps, the status flag and `irq` are zero.
- R2: With `esf_mode`=1, bit 0 of the byte for a timeslot in frames 6, 12, 18 and 24 becomes bits 3, 2, 1 and 0 of that channel's word. After the next `mf_end`, the word reads back at address = channel number (0..23), in rd_data[3:0], with rd_data[7:4]=0.
- R3: With `esf_mode`=0, the bit 0 from frame 6 goes to bits 3 and 1, and the bit 0 from frame 12 goes to bits 2 and 0.
- R4: Bytes of non-signaling frames, bits 7..1 of every byte, and bytes with a timeslot index of 24 or more have no effect on the stored words.
- R5: Change bitmaps sit at addresses 24, 25 and 26 and cover channels 0-7, 8-15 and 16-23. Channel 8k+j appears in bit 7-j of register 24+k. The bit is 1 exactly when that channel's new word differs from its previously stored word.
- R6: Each `mf_end` replaces all three bitmaps, so a channel that does not change in the next multiframe reads 0 afterwards.
- R7: The status flag reads as bit 5 of address 27 (other bits 0). It is set at an `mf_end` where at least one channel changed and `int_en`=1. It is not set when no channel changed or when `int_en`=0.
- R8: With `clr_on_read`=1, a read of address 27 returns the flag and then clears it. Writes to address 27 have no effect.
- R9: With `clr_on_read`=0, a write to address 27 with data bit 5 = 1 clears the flag. Reads, and writes with bit 5 = 0, leave it set.
- R10: `irq` is high exactly while the flag is set and `int_en`=1.
- R11: `rd_data` presents the addressed value in the cycle after `rd_en`. Addresses 28..31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esf_mode | input | 1 | 1: 24-frame A/B/C/D signaling, 0: 12-frame A/B signaling |
| int_en | input | 1 | Enables flag setting and the interrupt output |
| clr_on_read | input | 1 | 1: a read clears the flag, 0: a write of bit 5 clears it |
| byte_vld | input | 1 | Timeslot byte strobe |
| ts_byte | input | 8 | Received timeslot byte |
| ts_idx | input | 5 | Timeslot index of ts_byte |
| frame_num | input | 5 | Frame number within the multiframe, 1-based |
| mf_end | input | 1 | Multiframe boundary strobe |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Read data, one cycle after rd_en |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Signaling change interrupt |

## Verification
The hardest situation to reach is a change bitmap with exactly one bit set, in the correct bit position, while every other channel keeps its word unchanged. To get there, the stimulus must replay whole 24-frame multiframes in which all channels carry the same words as before except one. The bench therefore keeps a per-channel word table and regenerates all 576 bytes for every multiframe. It flips a single bit of one channel at the edge positions of each bank (channels 0, 7, 8, 15, 16, 23), so that the bit reversal within each register is pinned down. Noise on bit 0 in non-signaling frames shows that only the signaling frames are sampled.

// File: rtl/ds1sig_pkg.sv
package ds1sig_pkg;
  localparam int SIG_W  = 4;
  localparam int BANK_W = 8;
  localparam int FRM_W  = 5;

  // Place one received signaling bit into the channel word for the given frame.
  function automatic logic [SIG_W-1:0] merge_sig(
    input logic [SIG_W-1:0] old_w,
    input logic             sbit,
    input logic [FRM_W-1:0] frame,
    input logic             esf
  );
    logic [SIG_W-1:0] r;
    r = old_w;
    if (esf) begin
      case (frame)
        5'd6:    r[3] = sbit;
        5'd12:   r[2] = sbit;
        5'd18:   r[1] = sbit;
        5'd24:   r[0] = sbit;
        default: r = old_w;
      endcase
    end else begin
      case (frame)
        5'd6:    begin r[3] = sbit; r[1] = sbit; end
        5'd12:   begin r[2] = sbit; r[0] = sbit; end
        default: r = old_w;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/ds1_sig_gather.sv
module ds1_sig_gather
  import ds1sig_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int IDX_W  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         esf_mode,
  input  logic                         byte_vld,
  input  logic                         sig_bit,
  input  logic [IDX_W-1:0]             ts_idx,
  input  logic [FRM_W-1:0]             frame_num,
  output logic [NUM_CH-1:0][SIG_W-1:0] gath
);
  logic [NUM_CH-1:0][SIG_W-1:0] gath_d, gath_q;

  always_comb begin
    gath_d = gath_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ts_idx == IDX_W'(c)) begin
        gath_d[c] = merge_sig(gath_q[c], sig_bit, frame_num, esf_mode);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gath_q <= '0;
    end else if (byte_vld) begin
      gath_q <= gath_d;
    end
  end

  assign gath = gath_q;
endmodule

// File: rtl/ds1_sig_store.sv
module ds1_sig_store
  import ds1sig_pkg::*;
#(
  parameter int NUM_CH = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mf_end,
  input  logic [NUM_CH-1:0][SIG_W-1:0] gath,
  output logic [NUM_CH-1:0][SIG_W-1:0] store,
  output logic [NUM_CH-1:0]            chg,
  output logic                         any_chg
);
  logic [NUM_CH-1:0][SIG_W-1:0] store_q;
  logic [NUM_CH-1:0]            chg_d, chg_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign chg_d[c] = (gath[c] != store_q[c]);
  end

  assign any_chg = mf_end & (|chg_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      chg_q   <= '0;
    end else if (mf_end) begin
      store_q <= gath;
      chg_q   <= chg_d;
    end
  end

  assign store = store_q;
  assign chg   = chg_q;
endmodule

// File: rtl/ds1_sig_status.sv
module ds1_sig_status (
  input  logic clk,
  input  logic rst_n,
  input  logic any_chg,
  input  logic int_en,
  input  logic clr_on_read,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_clr_bit,
  output logic stat
);
  logic stat_d, stat_q, clr_ev, set_ev;

  assign clr_ev = clr_on_read ? rd_hit : (wr_hit & wr_clr_bit);
  assign set_ev = any_chg & int_en;

  always_comb begin
    stat_d = stat_q;
    if (clr_ev) stat_d = 1'b0;
    if (set_ev) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/ds1_sig_watch.sv
module ds1_sig_watch
  import ds1sig_pkg::*;
#(
  parameter int NUM_CH   = 24,
  parameter int IDX_W    = 5,
  parameter int ADDR_W   = 5,
  parameter int STAT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              esf_mode,
  input  logic              int_en,
  input  logic              clr_on_read,
  input  logic              byte_vld,
  input  logic [7:0]        ts_byte,
  input  logic [IDX_W-1:0]  ts_idx,
  input  logic [FRM_W-1:0]  frame_num,
  input  logic              mf_end,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              irq
);
  localparam int NUM_BANK  = NUM_CH / BANK_W;
  localparam int BANK_BASE = NUM_CH;
  localparam int STAT_ADDR = NUM_CH + NUM_BANK;

  logic [NUM_CH-1:0][SIG_W-1:0] gath, store;
  logic [NUM_CH-1:0]            chg;
  logic [NUM_BANK-1:0][BANK_W-1:0] bank_map;
  logic any_chg, stat_flag, rd_hit, wr_hit;
  logic [7:0] rd_data_d, rd_data_q;
  logic unused_bits;

  assign unused_bits = ^{ts_byte[7:1], wr_data};

  ds1_sig_gather #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .esf_mode (esf_mode),
    .byte_vld (byte_vld),
    .sig_bit  (ts_byte[0]),
    .ts_idx   (ts_idx),
    .frame_num(frame_num),
    .gath     (gath)
  );

  ds1_sig_store #(.NUM_CH(NUM_CH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .mf_end (mf_end),
    .gath   (gath),
    .store  (store),
    .chg    (chg),
    .any_chg(any_chg)
  );

  assign rd_hit = rd_en & (rd_addr == ADDR_W'(STAT_ADDR));
  assign wr_hit = wr_en & (wr_addr == ADDR_W'(STAT_ADDR));

  ds1_sig_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_chg    (any_chg),
    .int_en     (int_en),
    .clr_on_read(clr_on_read),
    .rd_hit     (rd_hit),
    .wr_hit     (wr_hit),
    .wr_clr_bit (wr_data[STAT_BIT]),
    .stat       (stat_flag)
  );

  // Lowest channel of each bank in the most significant bit.
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    for (genvar j = 0; j < BANK_W; j++) begin : g_bit
      assign bank_map[b][BANK_W-1-j] = chg[b*BANK_W + j];
    end
  end

  always_comb begin
    rd_data_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(c)) rd_data_d = {{(8-SIG_W){1'b0}}, store[c]};
    end
    for (int b = 0; b < NUM_BANK; b++) begin
      if (rd_addr == ADDR_W'(BANK_BASE + b)) rd_data_d = bank_map[b];
    end
    if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data_d[STAT_BIT] = stat_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data = rd_data_q;
  assign irq     = stat_flag & int_en;
endmodule

// File: rtl/ds1_sig_watch_chk.sv
module ds1_sig_watch_chk #(
  parameter int NUM_CH = 24,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mf_end,
  input logic              int_en,
  input logic              clr_on_read,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              irq,
  input logic              stat,
  input logic [NUM_CH-1:0] chg
);
  localparam int STAT_A = NUM_CH + NUM_CH / 8;

  a_r7_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> ($past(mf_end) && $past(int_en)));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_read && rd_en && rd_addr == ADDR_W'(STAT_A) && !mf_end) |=> !stat);

  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_read && wr_en && wr_addr == ADDR_W'(STAT_A) && wr_data[5] && !mf_end) |=> !stat);

  a_r9_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_read && stat && !wr_en) |=> stat);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);

  a_r6_bitmap_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_end |=> $stable(chg));

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > ADDR_W'(STAT_A)) |=> (rd_data == 8'h00));
endmodule

bind ds1_sig_watch ds1_sig_watch_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mf_end     (mf_end),
  .int_en     (int_en),
  .clr_on_read(clr_on_read),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .irq        (irq),
  .stat       (stat_flag),
  .chg        (chg)
);

// File: tb/ds1_sig_watch_test.sv
`timescale 1ns/1ps
module ds1_sig_watch_test;
  localparam int NCH = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic esf_mode, int_en, clr_on_read, byte_vld, mf_end, rd_en, wr_en;
  logic [7:0] ts_byte, wr_data;
  logic [7:0] rd_data;
  logic [4:0] ts_idx, frame_num, rd_addr, wr_addr;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] cur_v [NCH];
  logic [3:0] exp_store [NCH];
  logic       exp_chg [NCH];
  logic [7:0] d;

  always #2.5 clk = ~clk;

  ds1_sig_watch uut (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .int_en(int_en),
    .clr_on_read(clr_on_read), .byte_vld(byte_vld), .ts_byte(ts_byte),
    .ts_idx(ts_idx), .frame_num(frame_num), .mf_end(mf_end),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk); v = rd_data; rd_en = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = 5'(a); wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Send one multiframe of bytes from cur_v, then the boundary strobe; update the model.
  task automatic send_mf();
    logic [3:0] nw;
    for (int f = 1; f <= 24; f++) begin
      for (int t = 0; t < 26; t++) begin
        logic sb;
        sb = 1'((f + t) & 1);
        if (t < NCH) begin
          if (esf_mode && (f % 6 == 0)) sb = cur_v[t][3 - (f/6 - 1)];
          if (!esf_mode && f == 6)  sb = cur_v[t][3];
          if (!esf_mode && f == 12) sb = cur_v[t][2];
        end
        @(negedge clk);
        byte_vld = 1'b1; frame_num = 5'(f); ts_idx = 5'(t);
        ts_byte = {7'((f*13 + t*7) & 127), sb};
      end
    end
    @(negedge clk); byte_vld = 1'b0; mf_end = 1'b1;
    @(negedge clk); mf_end = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      nw = esf_mode ? cur_v[c] : {cur_v[c][3], cur_v[c][2], cur_v[c][3], cur_v[c][2]};
      exp_chg[c] = (nw != exp_store[c]);
      exp_store[c] = nw;
    end
  endtask

  task automatic check_banks(input string req);
    logic [7:0] e;
    logic [7:0] v;
    for (int b = 0; b < 3; b++) begin
      e = '0;
      for (int j = 0; j < 8; j++) e[7-j] = exp_chg[b*8 + j];
      rd(24 + b, v);
      check(req, v, e);
    end
  endtask

  task automatic check_store(input string req);
    logic [7:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(c, v);
      check(req, v, {4'h0, exp_store[c]});
    end
  endtask

  initial begin
    #900000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; esf_mode = 1'b1; int_en = 1'b1; clr_on_read = 1'b1;
    byte_vld = 1'b0; mf_end = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    ts_byte = '0; wr_data = '0; ts_idx = '0; frame_num = '0; rd_addr = '0; wr_addr = '0;
    for (int c = 0; c < NCH; c++) begin exp_store[c] = '0; exp_chg[c] = 1'b0; cur_v[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    rd(27, d); check("R1 status", d, 0);
    check_store("R1 store");
    check_banks("R1 bitmap");
    // R11 unmapped addresses
    for (int a = 28; a < 32; a++) begin rd(a, d); check("R11 unmapped", d, 0); end

    // Unchanged words: no flag (R7), noise ignored (R4)
    send_mf();
    check_store("R4 store after noise");
    check_banks("R5 no change");
    rd(27, d); check("R7 no change no flag", d, 0);

    // New pattern with enable off (R2, R5, R7)
    int_en = 1'b0;
    for (int c = 0; c < NCH; c++) cur_v[c] = 4'((c*5 + 3) & 15);
    send_mf();
    check_store("R2 esf store");
    check_banks("R5 bitmap pattern");
    check("R10 irq disabled", irq, 0);
    rd(27, d); check("R7 enable off", d, 0);

    // Same pattern again: bitmaps replaced with zero (R6)
    int_en = 1'b1;
    send_mf();
    check_banks("R6 bitmap refresh");
    rd(27, d); check("R7 repeat no flag", d, 0);

    // Single-channel toggles at bank edges (R5, R7, R8)
    foreach (exp_chg[k]) begin end
    for (int k = 0; k < 6; k++) begin
      int ch;
      ch = (k/2)*8 + (k%2)*7;
      cur_v[ch] = cur_v[ch] ^ 4'(1 << (k % 4));
      send_mf();
      check_banks("R5 single channel order");
      check_store("R2 toggled store");
      if (k == 0) begin
        check("R10 irq set", irq, 1);
        wr(27, 8'hFF);
        check("R8 write ignored", irq, 1);
        rd(27, d); check("R8 read returns flag", d, 8'h20);
        check("R8 irq after read", irq, 0);
        rd(27, d); check("R8 cleared", d, 0);
      end else begin
        rd(27, d); check("R7 flag set", d, 8'h20);
      end
    end

    // Write-to-clear mode (R9, R10)
    clr_on_read = 1'b0;
    cur_v[12] = cur_v[12] ^ 4'h8;
    send_mf();
    rd(27, d); check("R9 flag set", d, 8'h20);
    rd(27, d); check("R9 read keeps", d, 8'h20);
    wr(27, 8'hDF);
    rd(27, d); check("R9 bit5 zero keeps", d, 8'h20);
    @(negedge clk); int_en = 1'b0;
    @(negedge clk); check("R10 irq gated off", irq, 0);
    int_en = 1'b1;
    @(negedge clk); check("R10 irq back on", irq, 1);
    wr(27, 8'h20);
    rd(27, d); check("R9 write clears", d, 0);
    check("R10 irq after clear", irq, 0);

    // Superframe mode (R3)
    esf_mode = 1'b0;
    for (int c = 0; c < NCH; c++) cur_v[c] = 4'((c*3 + 1) & 15);
    send_mf();
    check_store("R3 sf store");
    check_banks("R3 sf bitmap");
    send_mf();
    check_banks("R6 sf repeat");
    check_store("R4 sf late frames ignored");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule